// File: doc/BRIEF.md
# Packed Floating-Point Lane Compare

This block compares two packed floating-point operands lane by lane and returns a lane mask. Each destination lane is all ones when the chosen relation holds for that lane pair and all zeros when it does not. Lanes can be half, single or double precision. The operand can be a 64-bit or 128-bit vector, or a single scalar lane. The relation is equal, greater-or-equal or greater-than. The two ordering relations can first strip the sign of both elements so that magnitudes are compared.

A 3-bit compare selector and the size and width controls are decoded inside the block. Reserved combinations of these controls produce an undefined indication instead of a result. Any invalid-operation condition in an active lane either pulses a trap output or sets a sticky flag, as the trap-enable input chooses. Each request is sampled on `in_valid`, and its result is registered one clock later.

Top module: `fpcmp_unit`

## Requirements
- R1: The selector `cmp_sel` decodes as follows: 000 = equal, 010 = greater-or-equal, 011 = greater-or-equal on magnitudes, 110 = greater-than, 111 = greater-than on magnitudes. Every other code sets `undef`, gives a zero mask and raises no invalid indication.
- R2: In magnitude mode, the sign bit (the top bit of each lane) of both elements is cleared before they are compared.
- R3: Every active lane of `lane_mask` is either all ones (the test passed) or all zeros (the test failed).
- R4: The element width is 16 bits when `fmt_half` is 1, whatever `fmt_dbl` holds. Otherwise it is 64 bits when `fmt_dbl` is 1 and 32 bits when it is 0.
- R5: In vector mode the data width is 128 bits when `vec_wide` is 1 and 64 bits when it is 0. The lane count is the data width divided by the element width, and mask bits above the data width read zero.
- R6: With `scalar_mode` set, only lane 0 (bits element-width-1 down to 0) is evaluated. All higher mask bits read zero.
- R7: `fmt_half`=0, `fmt_dbl`=1, `vec_wide`=0 and `scalar_mode`=0 together form a reserved combination. It sets `undef` and gives a zero mask.
- R8: A NaN has an all-ones exponent and a nonzero fraction. If either element of a lane is a NaN, the lane is unordered and every relation fails.
- R9: Positive zero and negative zero compare equal. Other values are ordered by sign and magnitude, so a more negative value is the smaller one.
- R10: The ordering relations flag invalid-operation for any NaN in an active lane. Equal flags it only for a signalling NaN, which is a NaN whose top fraction bit is 0.
- R11: When `trap_en`=1, an invalid operation pulses `inv_trap` with the result and leaves `inv_sticky` unchanged. When `trap_en`=0, it sets `inv_sticky`, which stays set until reset.
- R12: Reset clears every output. A request sampled with `in_valid` shows its result and `out_valid` after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | 128 | First packed operand |
| src_b | input | 128 | Second packed operand |
| fmt_half | input | 1 | Half-precision lanes |
| fmt_dbl | input | 1 | Double rather than single precision (when not half) |
| vec_wide | input | 1 | 128-bit rather than 64-bit vector |
| scalar_mode | input | 1 | Evaluate lane 0 only |
| cmp_sel | input | 3 | Relation selector |
| trap_en | input | 1 | Route invalid operation to trap rather than sticky flag |
| out_valid | output | 1 | Result strobe |
| lane_mask | output | 128 | Per-lane all-ones/all-zeros result |
| undef | output | 1 | Reserved control combination |
| inv_sticky | output | 1 | Accumulated invalid-operation flag |
| inv_trap | output | 1 | Invalid-operation trap pulse |

## Verification
The block has a single pipeline register, so a wrong decode, lane-activation count or sign handling shows up on `lane_mask` and `inv_trap` one clock after the request that causes it. A wrong active-lane count shows as nonzero bits above the data width, or as missing ones inside it. A fault in the flag routing may appear only on a later request, as a sticky flag that sets when it should not or fails to stay set. For that reason the sticky flag is checked both after a long run with traps enabled and on the requests that follow an invalid operation.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int VEC_W  = 128;
    localparam int MIN_EW = 16;
    localparam int MAX_LN = VEC_W / MIN_EW;
    localparam int CNT_W  = $clog2(MAX_LN) + 1;

    typedef enum logic [1:0] {
        OP_EQ = 2'd0,
        OP_GE = 2'd1,
        OP_GT = 2'd2
    } cmp_op_e;

    typedef enum logic [1:0] {
        ESZ_H = 2'd0,
        ESZ_S = 2'd1,
        ESZ_D = 2'd2
    } esz_e;

    typedef struct packed {
        cmp_op_e          op;
        logic             absm;
        logic             undef;
        esz_e             esz;
        logic [CNT_W-1:0] n_act;
    } ctrl_t;

    function automatic int exp_width(input int ew);
        if (ew == 16)      return 5;
        else if (ew == 32) return 8;
        else               return 11;
    endfunction

endpackage

// File: rtl/fpcmp_decode.sv
module fpcmp_decode
    import fpcmp_pkg::*;
(
    input  logic [2:0] cmp_sel,
    input  logic       fmt_half,
    input  logic       fmt_dbl,
    input  logic       vec_wide,
    input  logic       scalar_mode,
    output ctrl_t      ctrl
);
    localparam int WIDE_LN   = VEC_W / MIN_EW;
    localparam int NARROW_LN = (VEC_W / 2) / MIN_EW;

    logic             sel_bad;
    logic             size_bad;
    logic [CNT_W-1:0] base_cnt;
    logic [1:0]       shamt;

    always_comb begin
        sel_bad   = 1'b0;
        ctrl.op   = OP_EQ;
        ctrl.absm = 1'b0;
        case (cmp_sel)
            3'b000: ctrl.op = OP_EQ;
            3'b010: ctrl.op = OP_GE;
            3'b011: begin ctrl.op = OP_GE; ctrl.absm = 1'b1; end
            3'b110: ctrl.op = OP_GT;
            3'b111: begin ctrl.op = OP_GT; ctrl.absm = 1'b1; end
            default: sel_bad = 1'b1;
        endcase

        if (fmt_half)     ctrl.esz = ESZ_H;
        else if (fmt_dbl) ctrl.esz = ESZ_D;
        else              ctrl.esz = ESZ_S;

        size_bad   = !fmt_half && fmt_dbl && !vec_wide && !scalar_mode;
        ctrl.undef = sel_bad || size_bad;

        shamt    = 2'(ctrl.esz);
        base_cnt = vec_wide ? CNT_W'(WIDE_LN) : CNT_W'(NARROW_LN);
        if (scalar_mode) ctrl.n_act = CNT_W'(1);
        else             ctrl.n_act = base_cnt >> shamt;
    end

endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
    import fpcmp_pkg::*;
#(
    parameter int EW = 16
) (
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  cmp_op_e       op,
    input  logic          absm,
    output logic          pass,
    output logic          inv
);
    localparam int XW = exp_width(EW);
    localparam int FW = EW - 1 - XW;

    logic          sa, sb;
    logic [EW-2:0] ma, mb;
    logic          nan_a, nan_b, snan_a, snan_b;
    logic          unord, both_zero, eq, gt;

    always_comb begin
        sa = a[EW-1] && !absm;
        sb = b[EW-1] && !absm;
        ma = a[EW-2:0];
        mb = b[EW-2:0];

        nan_a  = (&ma[EW-2:FW]) && (|ma[FW-1:0]);
        nan_b  = (&mb[EW-2:FW]) && (|mb[FW-1:0]);
        snan_a = nan_a && !ma[FW-1];
        snan_b = nan_b && !mb[FW-1];

        unord     = nan_a || nan_b;
        both_zero = (ma == '0) && (mb == '0);
        eq        = !unord && (both_zero || (sa == sb && ma == mb));

        if (unord || both_zero) gt = 1'b0;
        else if (sa != sb)      gt = !sa;
        else if (sa)            gt = ma < mb;
        else                    gt = ma > mb;

        case (op)
            OP_EQ:   begin pass = eq;      inv = snan_a || snan_b; end
            OP_GE:   begin pass = gt || eq; inv = unord;           end
            OP_GT:   begin pass = gt;      inv = unord;           end
            default: begin pass = 1'b0;    inv = 1'b0;            end
        endcase
    end

endmodule

// File: rtl/fpcmp_lanes.sv
module fpcmp_lanes
    import fpcmp_pkg::*;
#(
    parameter int EW = 16
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  cmp_op_e          op,
    input  logic             absm,
    input  logic [CNT_W-1:0] n_act,
    output logic [VEC_W-1:0] mask,
    output logic             inv
);
    localparam int NL = VEC_W / EW;

    logic [NL-1:0] inv_vec;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic pass_i, inv_i, act_i;

        fpcmp_lane #(.EW(EW)) u_lane (
            .a    (a[i*EW +: EW]),
            .b    (b[i*EW +: EW]),
            .op   (op),
            .absm (absm),
            .pass (pass_i),
            .inv  (inv_i)
        );

        assign act_i               = CNT_W'(i) < n_act;
        assign mask[i*EW +: EW]    = {EW{pass_i && act_i}};
        assign inv_vec[i]          = inv_i && act_i;
    end

    assign inv = |inv_vec;

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [127:0]     src_a,
    input  logic [127:0]     src_b,
    input  logic             fmt_half,
    input  logic             fmt_dbl,
    input  logic             vec_wide,
    input  logic             scalar_mode,
    input  logic [2:0]       cmp_sel,
    input  logic             trap_en,
    output logic             out_valid,
    output logic [127:0]     lane_mask,
    output logic             undef,
    output logic             inv_sticky,
    output logic             inv_trap
);
    localparam int NPREC = 3;

    ctrl_t            ctrl;
    logic [VEC_W-1:0] mask_p [NPREC];
    logic [NPREC-1:0] inv_p;
    logic [VEC_W-1:0] mask_sel;
    logic             inv_sel;
    logic             inv_hit;

    fpcmp_decode u_dec (
        .cmp_sel     (cmp_sel),
        .fmt_half    (fmt_half),
        .fmt_dbl     (fmt_dbl),
        .vec_wide    (vec_wide),
        .scalar_mode (scalar_mode),
        .ctrl        (ctrl)
    );

    for (genvar p = 0; p < NPREC; p++) begin : g_prec
        fpcmp_lanes #(.EW(MIN_EW << p)) u_lanes (
            .a     (src_a),
            .b     (src_b),
            .op    (ctrl.op),
            .absm  (ctrl.absm),
            .n_act (ctrl.n_act),
            .mask  (mask_p[p]),
            .inv   (inv_p[p])
        );
    end

    always_comb begin
        case (ctrl.esz)
            ESZ_H:   begin mask_sel = mask_p[0]; inv_sel = inv_p[0]; end
            ESZ_S:   begin mask_sel = mask_p[1]; inv_sel = inv_p[1]; end
            default: begin mask_sel = mask_p[2]; inv_sel = inv_p[2]; end
        endcase
        inv_hit = inv_sel && !ctrl.undef;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            lane_mask  <= '0;
            undef      <= 1'b0;
            inv_sticky <= 1'b0;
            inv_trap   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            inv_trap  <= in_valid && inv_hit && trap_en;
            if (in_valid) begin
                lane_mask <= ctrl.undef ? '0 : mask_sel;
                undef     <= ctrl.undef;
                if (inv_hit && !trap_en) inv_sticky <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         vec_wide,
    input logic         scalar_mode,
    input logic         trap_en,
    input logic         out_valid,
    input logic [127:0] lane_mask,
    input logic         undef,
    input logic         inv_sticky,
    input logic         inv_trap
);
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r12_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r1_undef_silent: assert property (@(posedge clk) disable iff (rst)
        undef |-> (lane_mask == '0 && !inv_trap));

    a_r11_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        inv_sticky |=> inv_sticky);

    a_r11_trap_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !trap_en) |=> !inv_trap);

    a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (!vec_wide || scalar_mode)) |=> lane_mask[127:64] == '0);
endmodule

bind fpcmp_unit fpcmp_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .vec_wide    (vec_wide),
    .scalar_mode (scalar_mode),
    .trap_en     (trap_en),
    .out_valid   (out_valid),
    .lane_mask   (lane_mask),
    .undef       (undef),
    .inv_sticky  (inv_sticky),
    .inv_trap    (inv_trap)
);

// File: tb/tb_fpcmp_unit.sv
module tb_fpcmp_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVAL       = 13;
    localparam int WDOG       = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0, src_b = '0;
    logic         fmt_half = 1'b0, fmt_dbl = 1'b0, vec_wide = 1'b0, scalar_mode = 1'b0;
    logic [2:0]   cmp_sel = 3'b000;
    logic         trap_en = 1'b1;
    logic         out_valid, undef, inv_sticky, inv_trap;
    logic [127:0] lane_mask;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    fpcmp_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .fmt_half(fmt_half), .fmt_dbl(fmt_dbl), .vec_wide(vec_wide),
        .scalar_mode(scalar_mode), .cmp_sel(cmp_sel), .trap_en(trap_en),
        .out_valid(out_valid), .lane_mask(lane_mask), .undef(undef),
        .inv_sticky(inv_sticky), .inv_trap(inv_trap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cyc, WDOG);
            summary();
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int xw_of(input int ew);
        return (ew == 16) ? 5 : (ew == 32) ? 8 : 11;
    endfunction

    function automatic logic [63:0] mk(input int ew, input int idx);
        int xw = xw_of(ew);
        int fw = ew - 1 - xw;
        logic [63:0] bias = (64'd1 << (xw - 1)) - 1;
        logic [63:0] eall = (64'd1 << xw) - 1;
        logic [63:0] sgn  = 64'd1 << (ew - 1);
        logic [63:0] ftop = 64'd1 << (fw - 1);
        case (idx)
            0:  return 64'd0;
            1:  return sgn;
            2:  return bias << fw;
            3:  return sgn | (bias << fw);
            4:  return (bias + 1) << fw;
            5:  return sgn | ((bias + 1) << fw);
            6:  return (bias << fw) | ftop;
            7:  return eall << fw;
            8:  return sgn | (eall << fw);
            9:  return (eall << fw) | ftop;
            10: return (eall << fw) | 64'd1;
            11: return 64'd1;
            default: return sgn | (bias << fw) | ftop;
        endcase
    endfunction

    function automatic logic is_nan(input int ew, input logic [63:0] v);
        int xw = xw_of(ew);
        int fw = ew - 1 - xw;
        logic [63:0] e = (v >> fw) & ((64'd1 << xw) - 1);
        logic [63:0] f = v & ((64'd1 << fw) - 1);
        return (e == (64'd1 << xw) - 1) && (f != 0);
    endfunction

    function automatic logic is_snan(input int ew, input logic [63:0] v);
        int fw = ew - 1 - xw_of(ew);
        return is_nan(ew, v) && (((v >> (fw - 1)) & 64'd1) == 0);
    endfunction

    function automatic real fval(input int ew, input logic [63:0] v);
        int xw = xw_of(ew);
        int fw = ew - 1 - xw;
        int bias = (1 << (xw - 1)) - 1;
        int e = int'((v >> fw) & ((64'd1 << xw) - 1));
        real f = real'(v & ((64'd1 << fw) - 1)) / (2.0 ** fw);
        real m;
        if (e == (1 << xw) - 1) m = 1.0e300;
        else if (e == 0)        m = f * (2.0 ** (1 - bias));
        else                    m = (1.0 + f) * (2.0 ** (e - bias));
        return ((v >> (ew - 1)) & 64'd1) != 0 ? -m : m;
    endfunction

    // expected lane result from the requirement text (R1, R2, R8, R9, R10)
    task automatic ref_lane(input int ew, input logic [63:0] a0, input logic [63:0] b0,
                            input logic [2:0] sel, output logic pass, output logic inv);
        logic [63:0] a = a0, b = b0;
        logic nan;
        real fa, fb;
        if (sel[0]) begin
            a = a0 & ~(64'd1 << (ew - 1));
            b = b0 & ~(64'd1 << (ew - 1));
        end
        nan = is_nan(ew, a) || is_nan(ew, b);
        fa = fval(ew, a);
        fb = fval(ew, b);
        if (sel == 3'b000) begin
            pass = !nan && (fa == fb);
            inv  = is_snan(ew, a) || is_snan(ew, b);
        end else if (sel[2]) begin
            pass = !nan && (fa > fb);
            inv  = nan;
        end else begin
            pass = !nan && (fa >= fb);
            inv  = nan;
        end
    endtask

    task automatic issue();
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_fmt(input int ew);
        fmt_half = (ew == 16);
        fmt_dbl  = (ew == 64);
    endtask

    function automatic logic [127:0] put(input logic [127:0] vec, input int ew,
                                         input int k, input logic [63:0] v);
        logic [127:0] lm = (ew == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << ew) - 1);
        return (vec & ~(lm << (k * ew))) | ((128'(v) & lm) << (k * ew));
    endfunction

    initial begin
        logic [2:0] codes [5] = '{3'b000, 3'b010, 3'b011, 3'b110, 3'b111};
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset valid", 128'(out_valid), 128'd0);
        chk("R12 reset mask", lane_mask, 128'd0);
        chk("R12 reset flags", 128'({undef, inv_sticky, inv_trap}), 128'd0);
        rst = 1'b0;

        // sweep: all precisions, all defined relations, all value pairs, 128-bit vectors
        vec_wide = 1'b1; scalar_mode = 1'b0; trap_en = 1'b1;
        for (int p = 0; p < 3; p++) begin
            int ew = 16 << p;
            int nl = 128 / ew;
            set_fmt(ew);
            for (int c = 0; c < 5; c++) begin
                for (int i = 0; i < NVAL; i++) begin
                    for (int j = 0; j < NVAL; j++) begin
                        logic [127:0] em = '0;
                        logic et = 1'b0;
                        cmp_sel = codes[c];
                        for (int k = 0; k < nl; k++) begin
                            logic [63:0] va = mk(ew, (i + k) % NVAL);
                            logic [63:0] vb = mk(ew, (j + 2 * k) % NVAL);
                            logic ps, iv;
                            src_a = put(src_a, ew, k, va);
                            src_b = put(src_b, ew, k, vb);
                            ref_lane(ew, va, vb, codes[c], ps, iv);
                            em = put(em, ew, k, ps ? {64{1'b1}} : 64'd0);
                            et = et | iv;
                        end
                        issue();
                        chk("R3/R8/R9 sweep mask", lane_mask, em);
                        chk("R10/R11 sweep trap", 128'({out_valid, inv_trap}), 128'({1'b1, et}));
                    end
                end
            end
        end
        chk("R11 sticky untouched while trapping", 128'(inv_sticky), 128'd0);

        // R2: magnitude mode, -2 vs +1
        set_fmt(32); vec_wide = 1'b1;
        src_a = {4{32'hC000_0000}}; src_b = {4{32'h3F80_0000}};
        cmp_sel = 3'b111; issue();
        chk("R2 abs gt", lane_mask, {128{1'b1}});
        cmp_sel = 3'b110; issue();
        chk("R9 signed gt", lane_mask, 128'd0);

        // R5: 64-bit half vector
        set_fmt(16); vec_wide = 1'b0;
        src_a = {8{16'h4000}}; src_b = {8{16'h3C00}}; cmp_sel = 3'b110; issue();
        chk("R5 narrow half", lane_mask, {64'd0, {64{1'b1}}});
        // R4: fmt_dbl ignored in half mode
        fmt_dbl = 1'b1; issue();
        chk("R4 half ignores dbl", lane_mask, {64'd0, {64{1'b1}}});
        chk("R4 half not undef", 128'(undef), 128'd0);

        // R6: scalar single and double
        set_fmt(32); scalar_mode = 1'b1;
        src_a = {4{32'h4000_0000}}; src_b = {4{32'h3F80_0000}}; issue();
        chk("R6 scalar single", lane_mask, {96'd0, 32'hFFFF_FFFF});
        set_fmt(64); src_a = {2{64'h4000_0000_0000_0000}}; src_b = {2{64'h3FF0_0000_0000_0000}};
        issue();
        chk("R6 scalar double", lane_mask, {64'd0, {64{1'b1}}});
        scalar_mode = 1'b0; vec_wide = 1'b1; issue();
        chk("R5 wide double", lane_mask, {128{1'b1}});

        // R7: reserved size/width
        vec_wide = 1'b0; issue();
        chk("R7 reserved undef", 128'(undef), 128'd1);
        chk("R7 reserved mask", lane_mask, 128'd0);

        // R1: undefined selectors with NaN operands
        vec_wide = 1'b1; set_fmt(16);
        src_a = {8{16'h7C01}}; src_b = {8{16'h7C01}};
        for (int s = 0; s < 8; s++) begin
            if (s == 1 || s == 4 || s == 5) begin
                cmp_sel = 3'(s); issue();
                chk("R1 bad code undef", 128'(undef), 128'd1);
                chk("R1 bad code silent", 128'({inv_trap, |lane_mask}), 128'd0);
            end
        end

        // R11: sticky path
        trap_en = 1'b0; cmp_sel = 3'b110; issue();
        chk("R11 sticky set", 128'({inv_sticky, inv_trap}), 128'b10);
        src_a = {8{16'h4000}}; src_b = {8{16'h3C00}}; issue();
        chk("R11 sticky kept", 128'(inv_sticky), 128'd1);
        chk("R12 valid", 128'(out_valid), 128'd1);
        @(negedge clk);
        chk("R12 idle", 128'(out_valid), 128'd0);

        summary();
    end
endmodule